// File: doc/BRIEF.md
# Stream Staging FIFO with Drain Threshold

This block sits inside one channel of a data mover, between the side that fetches data and the side that stores it. In buffered mode it holds up to four 32-bit words. It tells the store side that it may start a burst only once the number of held words reaches a programmed fill level. The fill level is one, two, three or four quarters of the depth. The store side then pulls the announced number of words on consecutive read strobes. An end-of-transfer pulse lets the last words out one at a time, even when fewer words are held than the fill level asks for.

In pass-through mode the store holds a single item. Each item that arrives is offered on its own, and the fill level has no effect. Misuse is recorded in two sticky flags. The buffer flag covers a write to a full store, a read from an empty store, and a burst setting that is not legal. The pass-through flag covers a new item that arrives while the previous one is still waiting. Each flag is cleared by writing a one to its own clear bit.

Top module: `sfifo_stage`

## Requirements
- R1: After reset the level is 0, no burst is offered and both error flags are 0.
- R2: Words leave on `dst_data` in the order in which they were accepted; `dst_data` shows the oldest held word whenever the level is non-zero.
- R3: In buffered mode with single beats and no flush, `dst_avail` is 1 exactly when the level is at least the fill level and no burst is in progress. `thresh_sel` 00, 01, 10 and 11 select 1, 2, 3 and 4 words.
- R4: With `burst4`=1 and `thresh_sel`=11, a burst is offered at a level of 4 with `dst_beats`=4. `dst_avail` stays 0 until those 4 words have been read.
- R5: In pass-through mode (`fifo_mode`=0) at most one item is held. It is offered with `dst_beats`=1 for any `thresh_sel`.
- R6: In buffered mode, a write while 4 words are held and no read is made in the same cycle sets `fifo_err`. The word is dropped, and the level and contents stay unchanged.
- R7: A read strobe while the level is 0 sets `fifo_err` and removes nothing.
- R8: `burst4`=1 sets `fifo_err` in pass-through mode, or when `thresh_sel` is not 11.
- R9: In pass-through mode, a write while an item is held and not read in the same cycle sets `dm_err` and drops the new item.
- R10: An `eot` pulse starts a flush. While words remain, single-beat transfers are offered below the fill level. The flush ends when the store is empty.
- R11: `err_clr[0]` clears `fifo_err` and `err_clr[1]` clears `dm_err`. A set condition in the same cycle wins, and otherwise the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = buffered mode, 0 = pass-through mode |
| thresh_sel | input | 2 | Fill level in quarters of the depth, minus one |
| burst4 | input | 1 | 1 = the store side uses 4-beat bursts |
| src_wr | input | 1 | Write strobe from the fetch side |
| src_data | input | DW | Word to store |
| dst_rd | input | 1 | Read strobe from the store side |
| dst_data | output | DW | Oldest held word |
| dst_avail | output | 1 | A burst of `dst_beats` words may start |
| dst_beats | output | CW | Number of beats in the offered burst |
| eot | input | 1 | End-of-transfer pulse that starts a flush |
| err_clr | input | 2 | Write-one-to-clear: bit 0 clears the buffer flag, bit 1 clears the pass-through flag |
| fifo_err | output | 1 | Sticky buffer error flag |
| dm_err | output | 1 | Sticky pass-through error flag |
| fifo_level | output | CW | Number of held words |

## Verification
The hardest cases come from how strobes line up in a single cycle. These are a write to a full store with a read in the same cycle (no error) and without one (an error). Another is a read strobe given in the middle of a 4-beat burst, while `dst_avail` is already low. Random traffic reaches these by reading only some of the time, both when a burst is offered and when it is not. This keeps the store sitting at its limits. Directed sequences cover each of the remaining cases: the first read of a burst, a flush that begins below the fill level, and a clear strobe that meets a new error in the same cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    // Fill-level selector encoding (quarters of depth, minus one)
    typedef enum logic [1:0] {
        THR_QUARTER = 2'b00,
        THR_HALF    = 2'b01,
        THR_3QUART  = 2'b10,
        THR_FULL    = 2'b11
    } thr_sel_e;

    // Sticky error flag pair
    typedef struct packed {
        logic fe;
        logic dme;
    } err_flags_t;

    // Beats in one incrementing burst
    localparam int unsigned BURST_LEN = 4;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (push) begin
            mem_d[ptr_q.wr] = wdata;
            ptr_d.wr        = nxt(ptr_q.wr);
        end
        if (pop) ptr_d.rd = nxt(ptr_q.rd);
        case ({push, pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + CW'(1);
            2'b01:   ptr_d.cnt = ptr_q.cnt - CW'(1);
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rdata = mem_q[ptr_q.rd];
    assign level = ptr_q.cnt;
endmodule

// File: rtl/sfifo_drain.sv
module sfifo_drain #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic [1:0]    thresh_sel,
    input  logic          burst4,
    input  logic          eot,
    input  logic          pop,
    input  logic [CW-1:0] level,
    output logic          avail,
    output logic [CW-1:0] beats
);
    import sfifo_pkg::*;

    localparam logic [CW-1:0] BL = CW'(BURST_LEN);

    typedef struct packed {
        logic          flush;
        logic [CW-1:0] left;
    } drn_t;

    drn_t          st_d, st_q;
    logic [CW+1:0] thr_w;
    logic          cond;

    always_comb begin
        thr_w = (CW+2)'(((int'(thresh_sel) + 1) * int'(DEPTH)) / 4);
        if (!fifo_mode || st_q.flush) beats = CW'(1);
        else                          beats = burst4 ? BL : CW'(1);

        if (!fifo_mode || st_q.flush) cond = (level != '0);
        else cond = ({2'b00, level} >= thr_w) && (level >= beats);
        avail = (st_q.left == '0) && cond;

        st_d       = st_q;
        st_d.flush = eot || (st_q.flush && level != '0);
        if (pop) begin
            if (st_q.left != '0) st_d.left = st_q.left - CW'(1);
            else if (avail)      st_d.left = beats - CW'(1);
            else                 st_d.left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sfifo_err.sv
module sfifo_err (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fe_set,
    input  logic       dme_set,
    input  logic [1:0] clr,
    output logic       fe,
    output logic       dme
);
    import sfifo_pkg::*;

    err_flags_t fl_d, fl_q;

    always_comb begin
        fl_d.fe  = fe_set  || (fl_q.fe  && !clr[0]);
        fl_d.dme = dme_set || (fl_q.dme && !clr[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign fe  = fl_q.fe;
    assign dme = fl_q.dme;
endmodule

// File: rtl/sfifo_stage.sv
module sfifo_stage #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic [1:0]    thresh_sel,
    input  logic          burst4,
    input  logic          src_wr,
    input  logic [DW-1:0] src_data,
    input  logic          dst_rd,
    output logic [DW-1:0] dst_data,
    output logic          dst_avail,
    output logic [CW-1:0] dst_beats,
    input  logic          eot,
    input  logic [1:0]    err_clr,
    output logic          fifo_err,
    output logic          dm_err,
    output logic [CW-1:0] fifo_level
);
    import sfifo_pkg::*;

    logic [CW-1:0] level, cap;
    logic          pop, push, room, over, cfg_bad, fe_set, dme_set;

    always_comb begin
        cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
        pop     = dst_rd && (level != '0);
        room    = (level < cap) || pop;
        push    = src_wr && room;
        over    = src_wr && !room;
        cfg_bad = burst4 && (!fifo_mode || thresh_sel != THR_FULL);
        fe_set  = (over && fifo_mode) || (dst_rd && level == '0) || cfg_bad;
        dme_set = over && !fifo_mode;
    end

    sfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (src_data),
        .rdata (dst_data),
        .level (level)
    );

    sfifo_drain #(.DEPTH(DEPTH)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .thresh_sel (thresh_sel),
        .burst4     (burst4),
        .eot        (eot),
        .pop        (pop),
        .level      (level),
        .avail      (dst_avail),
        .beats      (dst_beats)
    );

    sfifo_err u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .fe_set  (fe_set),
        .dme_set (dme_set),
        .clr     (err_clr),
        .fe      (fifo_err),
        .dme     (dm_err)
    );

    assign fifo_level = level;
endmodule

// File: rtl/sfifo_stage_chk.sv
module sfifo_stage_chk #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_mode,
    input logic [1:0]    thresh_sel,
    input logic          burst4,
    input logic          src_wr,
    input logic [DW-1:0] src_data,
    input logic          dst_rd,
    input logic [DW-1:0] dst_data,
    input logic          dst_avail,
    input logic [CW-1:0] dst_beats,
    input logic          eot,
    input logic [1:0]    err_clr,
    input logic          fifo_err,
    input logic          dm_err,
    input logic [CW-1:0] fifo_level
);
    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= CW'(DEPTH));

    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode && src_wr && fifo_level == CW'(DEPTH) && !dst_rd
        |=> fifo_err && fifo_level == CW'(DEPTH));

    assert_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_rd && fifo_level == '0 |=> fifo_err);

    assert_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst4 && (!fifo_mode || thresh_sel != 2'b11) |=> fifo_err);

    assert_dme_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode && src_wr && fifo_level != '0 && !dst_rd |=> dm_err);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err && !err_clr[0] |=> fifo_err);

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr[1] && !(!fifo_mode && src_wr && fifo_level != '0 && !dst_rd)
        |=> !dm_err);

    assert_avail_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dst_avail |-> fifo_level != '0);

    assert_burst_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dst_avail && dst_beats == CW'(4) |-> fifo_level >= CW'(4));

    assert_direct_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode && dst_avail |-> dst_beats == CW'(1));
endmodule

bind sfifo_stage sfifo_stage_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_sfifo_stage.sv
module tb_sfifo_stage;
    localparam int DW = 32;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_mode = 1'b1;
    logic [1:0]    thresh_sel = 2'b00;
    logic          burst4 = 1'b0;
    logic          src_wr = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          dst_rd = 1'b0;
    logic [DW-1:0] dst_data;
    logic          dst_avail;
    logic [CW-1:0] dst_beats;
    logic          eot = 1'b0;
    logic [1:0]    err_clr = 2'b00;
    logic          fifo_err, dm_err;
    logic [CW-1:0] fifo_level;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mq[$];
    logic        m_fe, m_dme, m_flush;
    int          m_left;

    always #4 clk = ~clk;

    sfifo_stage #(.DW(DW), .DEPTH(4)) dut (.*);

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_beats();
        if (!fifo_mode || m_flush) return 1;
        return burst4 ? 4 : 1;
    endfunction

    function automatic logic exp_avail();
        int  n = mq.size();
        logic c;
        if (!fifo_mode || m_flush) c = (n > 0);
        else c = (n >= int'(thresh_sel) + 1) && (n >= exp_beats());
        return (m_left == 0) && c;
    endfunction

    task automatic step(input logic wr, input logic [31:0] d, input logic rd,
                        input logic e, input logic [1:0] clr, input string tag);
        int   n, cap, nl;
        logic ea, pop, over, fes, dmes, nf;
        src_wr = wr; src_data = d; dst_rd = rd; eot = e; err_clr = clr;
        #1;
        n  = mq.size();
        ea = exp_avail();
        check(tag, "level", 32'(fifo_level), 32'(n));
        check(tag, "avail", 32'(dst_avail), 32'(ea));
        if (ea) check(tag, "beats", 32'(dst_beats), 32'(exp_beats()));
        if (n > 0) check("R2", "head", dst_data, mq[0]);
        check(tag, "fifo_err", 32'(fifo_err), 32'(m_fe));
        check(tag, "dm_err", 32'(dm_err), 32'(m_dme));
        cap  = fifo_mode ? 4 : 1;
        pop  = rd && n > 0;
        over = wr && !(n < cap || pop);
        fes  = (over && fifo_mode) || (rd && n == 0) ||
               (burst4 && (!fifo_mode || thresh_sel != 2'b11));
        dmes = over && !fifo_mode;
        nf   = e || (m_flush && n != 0);
        if (pop) nl = (m_left != 0) ? m_left - 1 : (ea ? exp_beats() - 1 : 0);
        else     nl = m_left;
        @(posedge clk);
        m_fe    = fes  || (m_fe  && !clr[0]);
        m_dme   = dmes || (m_dme && !clr[1]);
        m_flush = nf;
        m_left  = nl;
        if (pop) void'(mq.pop_front());
        if (wr && !over) mq.push_back(d);
        @(negedge clk);
        src_wr = 0; dst_rd = 0; eot = 0; err_clr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; src_wr = 0; dst_rd = 0; eot = 0; err_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        mq.delete(); m_fe = 0; m_dme = 0; m_flush = 0; m_left = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: reset state
        do_reset();
        step(0, 0, 0, 0, 0, "R1");

        // R3 / R2: random buffered traffic at each fill level
        for (int s = 0; s < 4; s++) begin
            fifo_mode = 1; burst4 = 0; thresh_sel = 2'(s);
            do_reset();
            for (int i = 0; i < 300; i++) begin
                logic rd;
                rd = exp_avail() ? ($urandom % 3 != 0) : ($urandom % 8 == 0);
                step($urandom % 2, $urandom, rd, 0,
                     ($urandom % 16 == 0) ? 2'b11 : 2'b00, "R3");
            end
        end

        // R5 / R9: random pass-through traffic
        fifo_mode = 0; thresh_sel = 2'b10; do_reset();
        for (int i = 0; i < 300; i++) begin
            thresh_sel = 2'($urandom);
            step($urandom % 2, $urandom, $urandom % 2, 0,
                 ($urandom % 12 == 0) ? 2'b11 : 2'b00, "R5");
        end

        // R6: overrun keeps contents, simultaneous read and write is allowed
        fifo_mode = 1; thresh_sel = 2'b11; do_reset();
        for (int i = 0; i < 4; i++) step(1, 32'hA0 + i, 0, 0, 0, "R6");
        step(1, 32'hDEAD, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 2'b01, "R6");
        step(1, 32'hB0, 1, 0, 0, "R6");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, "R6");

        // R7: underrun
        do_reset();
        step(0, 0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 0, "R7");

        // R4: four-beat burst
        burst4 = 1; thresh_sel = 2'b11; do_reset();
        for (int i = 0; i < 4; i++) step(1, 32'hC0 + i, 0, 0, 0, "R4");
        step(0, 0, 1, 0, 0, "R4");
        step(1, 32'hC8, 1, 0, 0, "R4");
        step(1, 32'hC9, 1, 0, 0, "R4");
        step(1, 32'hCA, 1, 0, 0, "R4");
        step(1, 32'hCB, 0, 0, 0, "R4");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, "R4");
        step(0, 0, 0, 0, 0, "R4");

        // R8: illegal burst settings
        thresh_sel = 2'b01; do_reset();
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        fifo_mode = 0; thresh_sel = 2'b11; burst4 = 0; do_reset();
        burst4 = 1;
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        burst4 = 0;

        // R9 / R5: pass-through second request
        do_reset();
        step(1, 32'h11, 0, 0, 0, "R5");
        step(1, 32'h22, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(1, 32'h33, 1, 0, 0, "R9");
        step(0, 0, 1, 0, 0, "R5");

        // R10: flush below fill level
        fifo_mode = 1; thresh_sel = 2'b11; do_reset();
        step(1, 32'hF1, 0, 0, 0, "R10");
        step(1, 32'hF2, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, "R10");
        step(0, 0, 1, 0, 0, "R10");
        step(0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R10");
        step(1, 32'hF3, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R10");

        // R11: set wins over clear, then clear alone
        do_reset();
        step(0, 0, 1, 0, 2'b01, "R11");
        step(0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 2'b01, "R11");
        step(0, 0, 0, 0, 0, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule